// File: doc/BRIEF.md
# Latched Status Register Group

This block collects up to sixteen live instrument conditions and turns them into status that a controller can poll or be alerted by. It has three views of each condition bit. The first is the condition itself, read straight from the input with no delay. The second is an event bit that catches the moment the condition turns on and then holds it. The third is a mask that decides whether that event counts toward a single summary flag. The summary flag drives one bit of a higher-level status byte.

Only four condition positions are populated: temperature overload on bit 4, resistance overload on bit 9, upper limit-test failure on bit 11 and lower limit-test failure on bit 12. Together these form the parameter mask `16'h1A10`. Every other position is tied off.

A controller accesses the three views through a small register port. Address 0 is the live condition and is read-only. Address 1 is the event register; it is read-only and clears when it is read. Address 2 is the mask and can be read and written. A separate clear strobe empties the event register at any time.

Top module: `stat_group`

## Requirements
- R1: With `rd_en` high and `addr` = 0, `rdata` shows `cond_in` masked to the populated bits in the same cycle, with no register delay.
- R2: When a populated condition bit goes from 0 to 1 between two clock edges, its event bit is set at the next edge and reads as 1 at address 1 in the following cycle.
- R3: Once an event bit is set, it stays set when its condition later falls or rises again.
- R4: A read of address 1 returns the event register and clears it at the same edge. A rising edge that lands in the same cycle as the read still leaves its bit set.
- R5: A one-cycle `clr_stat` pulse clears every event bit. A rising edge in that same cycle still leaves its bit set.
- R6: A write with `wr_en` high and `addr` = 2 loads the mask from `wdata`, and the new value reads back at address 2. The write never changes the event register.
- R7: `summary` is 1 exactly when some bit is set in both the event register and the mask. It follows a change in either of them in the cycle after the edge that made the change.
- R8: Bits outside the populated set (mask `16'h1A10`: bit 4 temperature, bit 9 resistance, bit 11 upper limit, bit 12 lower limit) read as 0 at every address. They never set an event and never raise `summary`.
- R9: Reset clears the event register and the mask. A condition that is already high while reset is released does not create an event.
- R10: `rdata` is 0 whenever `rd_en` is low, and it is 0 when address 3 is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_in | input | 16 | Live condition vector |
| rd_en | input | 1 | Read strobe for the register port |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register select: 0 condition, 1 event, 2 mask |
| wdata | input | 16 | Write data for the mask |
| clr_stat | input | 1 | Clear strobe for the event register |
| rdata | output | 16 | Read data (combinational) |
| summary | output | 1 | OR of the masked, latched events |

## Verification
The assertions check on every cycle the rules that relate one edge to the next:
- a fresh rising edge always lands in the event register;
- event bits only fall after a read of address 1 or a clear pulse;
- a mask write leaves the events untouched;
- unpopulated bits stay zero;
- `summary` never rises without a set event and a set mask bit.

The bench scenarios cover what only an end-to-end sequence can show:
- the exact read-back values;
- that the clear-on-read and the clear strobe both keep an edge arriving in the same cycle;
- that a condition already high during reset stays silent;
- the one-cycle lag of `summary` behind a mask write.

// File: rtl/stat_group.sv
module stat_group #(
  parameter int W = 16,
  parameter logic [W-1:0] USED_MASK = 16'h1A10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_in,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         clr_stat,
  output logic [W-1:0] rdata,
  output logic         summary
);
  localparam logic [1:0] A_COND = 2'd0;
  localparam logic [1:0] A_EVT  = 2'd1;
  localparam logic [1:0] A_ENA  = 2'd2;

  logic [W-1:0] cond_m, prev_q, ev_q, en_q, rise;
  logic         armed_q, rd_evt, wr_ena;

  assign cond_m = cond_in & USED_MASK;
  assign rise   = armed_q ? (cond_m & ~prev_q) : '0;
  assign rd_evt = rd_en && (addr == A_EVT);
  assign wr_ena = wr_en && (addr == A_ENA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= '0;
      ev_q    <= '0;
      en_q    <= '0;
    end else begin
      armed_q <= 1'b1;
      prev_q  <= cond_m;
      ev_q    <= ((rd_evt || clr_stat) ? '0 : ev_q) | rise;
      if (wr_ena) en_q <= wdata & USED_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_COND:  rdata = cond_m;
        A_EVT:   rdata = ev_q;
        A_ENA:   rdata = en_q;
        default: rdata = '0;
      endcase
    end
  end

  assign summary = |(ev_q & en_q);
endmodule

// File: rtl/stat_group_chk.sv
module stat_group_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] USED_MASK = 16'h1A10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cond_in,
  input logic         rd_en,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic         clr_stat,
  input logic [W-1:0] ev_q,
  input logic [W-1:0] en_q,
  input logic         summary
);
  logic [W-1:0] c_q, cm, edges;
  logic         vld_q, clr_any;

  assign cm      = cond_in & USED_MASK;
  assign edges   = vld_q ? (cm & ~c_q) : '0;
  assign clr_any = clr_stat || (rd_en && addr == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      c_q   <= '0;
    end else begin
      vld_q <= 1'b1;
      c_q   <= cm;
    end
  end

  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> ((ev_q & $past(edges)) == $past(edges)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_any |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1) |=> ((ev_q & ~$past(edges)) == '0));

  p_clr_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |=> ((ev_q & ~$past(edges)) == '0));

  p_wr_keeps_ev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !clr_any && edges == '0) |=> $stable(ev_q));

  p_summary_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    summary |-> (ev_q != '0 && en_q != '0));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q & ~USED_MASK) == '0) && ((en_q & ~USED_MASK) == '0));

  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> (ev_q == '0 && en_q == '0));
endmodule

bind stat_group stat_group_chk #(.W(W), .USED_MASK(USED_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .clr_stat(clr_stat), .ev_q(ev_q), .en_q(en_q), .summary(summary)
);

// File: tb/sim_stat_group.sv
module sim_stat_group;
  localparam logic [15:0] T = 16'h0010, O = 16'h0200, H = 16'h0800, L = 16'h1000;
  localparam logic [15:0] M = 16'h1A10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cond_in = '0, wdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, clr_stat = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] rdata;
  logic        summary;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] rd;
    logic        sm;
    bit          crd;
    bit          csm;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  stat_group u0 (.clk(clk), .rst_n(rst_n), .cond_in(cond_in), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .clr_stat(clr_stat),
    .rdata(rdata), .summary(summary));

  task automatic cyc(input logic [15:0] c, input logic rd, input logic wr,
                     input logic [1:0] a, input logic [15:0] wd, input logic cl,
                     input logic [15:0] erd, input logic esm,
                     input bit crd, input bit csm, input string tag);
    item_t it;
    @(posedge clk); #1;
    cond_in = c; rd_en = rd; wr_en = wr; addr = a; wdata = wd; clr_stat = cl;
    it.rd = erd; it.sm = esm; it.crd = crd; it.csm = csm; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.crd) begin
        checks++;
        if (rdata !== it.rd) begin
          errors++;
          $display("FAIL %s rdata actual %h expected %h", it.tag, rdata, it.rd);
        end
      end
      if (it.csm) begin
        checks++;
        if (summary !== it.sm) begin
          errors++;
          $display("FAIL %s summary actual %b expected %b", it.tag, summary, it.sm);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cond_in = T;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: condition high through reset creates no event
    cyc(T, 1, 0, 2'd1, 0, 0, 16'h0, 0, 1, 1, "R9 no event from reset-high");
    cyc(T, 1, 0, 2'd1, 0, 0, 16'h0, 0, 1, 1, "R9 still no event");
    cyc(T, 1, 0, 2'd2, 0, 0, 16'h0, 0, 1, 0, "R9 mask cleared");
    // R1 / R8 live condition, unused bit hidden
    cyc(T | 16'h0001, 1, 0, 2'd0, 0, 0, T, 0, 1, 0, "R1 R8 live condition");
    // R2 rising edge
    cyc(T | H, 0, 0, 2'd0, 0, 0, 16'h0, 0, 1, 0, "R10 idle read zero");
    cyc(T | H, 1, 0, 2'd1, 0, 0, H, 0, 1, 0, "R2 edge latched");
    cyc(T | H, 1, 0, 2'd1, 0, 0, 16'h0, 0, 1, 0, "R4 read cleared");
    cyc(T, 1, 0, 2'd1, 0, 0, 16'h0, 0, 1, 0, "R3 falling makes no event");
    // R3 held after condition drops
    cyc(T | L, 0, 0, 2'd0, 0, 0, 16'h0, 0, 0, 0, "");
    cyc(T, 1, 0, 2'd1, 0, 0, L, 0, 1, 0, "R3 event kept after fall");
    // R6 / R7 mask and summary
    cyc(T, 0, 1, 2'd2, 16'hFFFF, 0, 16'h0, 0, 0, 1, "R7 no events no summary");
    cyc(T, 1, 0, 2'd2, 0, 0, M, 0, 1, 0, "R6 R8 mask readback");
    cyc(T | O, 0, 0, 2'd0, 0, 0, 16'h0, 0, 0, 1, "R7 summary waits for edge");
    cyc(T | O, 0, 0, 2'd0, 0, 0, 16'h0, 1, 1, 1, "R7 summary raised");
    cyc(T | O, 0, 1, 2'd2, 16'h0000, 0, 16'h0, 1, 0, 1, "R7 summary before mask edge");
    cyc(T | O, 1, 0, 2'd1, 0, 0, O, 0, 1, 1, "R6 write kept event, R7 masked");
    cyc(T | O, 1, 0, 2'd3, 0, 0, 16'h0, 0, 1, 0, "R10 addr3 zero");
    // R4 edge during read-clear survives
    cyc(16'h0, 0, 0, 2'd0, 0, 0, 16'h0, 0, 0, 0, "");
    cyc(L, 0, 0, 2'd0, 0, 0, 16'h0, 0, 0, 0, "");
    cyc(L | H, 1, 0, 2'd1, 0, 0, L, 0, 1, 0, "R4 read returns event");
    cyc(L | H, 1, 0, 2'd1, 0, 0, H, 0, 1, 0, "R4 same-cycle edge kept");
    // R5 clear strobe
    cyc(L | H | O, 0, 0, 2'd0, 0, 0, 16'h0, 0, 0, 0, "");
    cyc(L | H | O | T, 0, 0, 2'd0, 0, 1, 16'h0, 0, 0, 0, "");
    cyc(L | H | O | T, 1, 0, 2'd1, 0, 0, T, 0, 1, 0, "R5 clear kept same-cycle edge");
    // R8 unused bit never sets event or summary
    cyc(L | H | O | T | 16'h0001, 0, 1, 2'd2, 16'hFFFF, 0, 16'h0, 0, 0, 0, "");
    cyc(L | H | O | T | 16'h0001, 1, 0, 2'd1, 0, 0, 16'h0, 0, 1, 1, "R8 unused no event");
    cyc(H, 1, 0, 2'd0, 0, 0, H, 0, 1, 0, "R1 same-cycle condition");
    cyc(H, 1, 0, 2'd2, 0, 0, M, 0, 1, 0, "R6 mask readback");
    // R9 reset mid-run
    @(posedge clk); #1;
    rd_en = 0; wr_en = 0; clr_stat = 0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(H, 1, 0, 2'd2, 0, 0, 16'h0, 0, 1, 1, "R9 reset cleared mask");
    cyc(H, 1, 0, 2'd1, 0, 0, 16'h0, 0, 1, 1, "R9 reset cleared events");
    cyc(H, 0, 0, 2'd0, 0, 0, 16'h0, 0, 0, 0, "");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule